// File: doc/BRIEF.md
# Real-Mode Address Generator with Bit-20 Gate

This block turns a processor memory request into a 24-bit system bus address. In real mode it forms the address from a 16-bit segment and a 16-bit offset. The segment is multiplied by sixteen and the offset is added. The sum can carry into bit 20. In protected mode it takes a 24-bit linear address unchanged.

Both paths then pass through a gate on bit 20 that software controls. While the gate is closed, bit 20 of the outgoing address is cleared. This restores the 1 MB wrap-around that older 20-bit code expects. Bits 21 to 23 are never touched, so with the gate closed only odd-numbered megabytes fold down by 1 MB.

Boot firmware opens the gate to reach all of memory and closes it again before legacy code runs. The gate state sits in a one-bit register with a write strobe and a read-back port. The address and its valid strobe leave the block through one register stage.

Top module: `rm_addr_gen`

## Requirements
- R1: After a synchronous active-high reset, `gate_state_o` is 0 (gate closed), `addr_valid_o` is 0 and `addr_o` is 0.
- R2: With `prot_mode_i` = 0 (real mode) and the gate open, the address captured for a request equals segment×16 + offset as a 21-bit sum, zero-extended to 24 bits. For example, F800:8000 gives 0x100000 and FFFF:FFFF gives 0x10FFEF.
- R3: With the gate closed, bit 20 of every captured address is 0 and all other bits match the ungated address. For example, F800:8000 gives 0x000000 and FFFF:FFFF gives 0x00FFEF.
- R4: With `prot_mode_i` = 1, the captured address is `lin_addr_i`, with bit 20 cleared while the gate is closed and bits 21 to 23 always passed through. For example, with the gate closed, 0xF12345 gives 0xE12345 and 0x2ABCDE is unchanged.
- R5: When `gate_we_i` is 1 at a clock edge, `gate_state_o` takes `gate_wdata_i` after that edge (1 = open). Without a write strobe the state holds.
- R6: A request in the same cycle as a gate write uses the gate state from before that write.
- R7: `addr_valid_o` repeats `req_valid_i` one clock later. `addr_o` loads only on a valid request and otherwise keeps its last value, whatever the other inputs do.
- R8: Distinct segment:offset pairs that name the same byte give the same address. F000:FFFF, FFFF:000F, F800:7FFF and FFF0:00FF all give 0x0FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present this cycle |
| prot_mode_i | input | 1 | 0 = segment:offset path, 1 = linear address path |
| seg_i | input | 16 | Real-mode segment |
| off_i | input | 16 | Real-mode offset |
| lin_addr_i | input | 24 | Protected-mode linear address |
| gate_we_i | input | 1 | Gate register write strobe |
| gate_wdata_i | input | 1 | New gate state (1 = bit 20 passes) |
| gate_state_o | output | 1 | Current gate state |
| addr_o | output | 24 | Registered system address |
| addr_valid_o | output | 1 | Registered address strobe |

## Verification
A sweep of segments spread across the whole 16-bit range is crossed with sixteen offsets, including 0, 0x000F, 0x8000 and 0xFFFF, under both gate states. This exercises sums below 1 MB, sums that just carry into bit 20, and the largest sum. Together they separate a correct shift-and-add from a missing carry or a wrong shift, and a gated bit 20 from one that passes.

Fixed aliasing pairs and the F800:8000 and FFFF:FFFF corner cases pin the wrap-around values exactly. Linear addresses with bit 20 set and clear, and with high bits set, show that the gate clears only bit 20 and leaves the higher megabytes alone. A write placed in the same cycle as a request, and idle cycles with changing inputs, expose the ordering of the gate register and the hold behaviour of the output register.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;
  typedef enum logic {
    MODE_REAL = 1'b0,
    MODE_PROT = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/rm_seg_adder.sv
// Combinational segment:offset sum, zero-extended to the bus width.
module rm_seg_adder #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int OUT_W = 24
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [OUT_W-1:0] sum_o
);
  logic [OUT_W-1:0] seg_ext;
  logic [OUT_W-1:0] off_ext;

  always_comb begin
    seg_ext = OUT_W'(seg_i) << SHIFT;
    off_ext = OUT_W'(off_i);
    sum_o   = seg_ext + off_ext;
  end
endmodule

// File: rtl/rm_gate_reg.sv
// One-bit software gate register; a write lands on the next edge.
module rm_gate_reg (
  input  logic clk,
  input  logic rst,
  input  logic we_i,
  input  logic wdata_i,
  output logic state_o
);
  always_ff @(posedge clk) begin
    if (rst) state_o <= 1'b0;
    else if (we_i) state_o <= wdata_i;
  end
endmodule

// File: rtl/rm_bit_gate.sv
// Clears a single bit position of a word unless the gate passes it.
module rm_bit_gate #(
  parameter int W   = 24,
  parameter int BIT = 20
) (
  input  logic [W-1:0] in_i,
  input  logic         pass_i,
  output logic [W-1:0] out_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g == BIT) begin : g_gated
      assign out_o[g] = in_i[g] & pass_i;
    end else begin : g_thru
      assign out_o[g] = in_i[g];
    end
  end
endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen #(
  parameter int SEG_W    = 16,
  parameter int OFF_W    = 16,
  parameter int SHIFT    = 4,
  parameter int ADDR_W   = 24,
  parameter int GATE_BIT = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              prot_mode_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [ADDR_W-1:0] lin_addr_i,
  input  logic              gate_we_i,
  input  logic              gate_wdata_i,
  output logic              gate_state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o
);
  import rm_addr_pkg::*;

  addr_mode_e        mode;
  logic [ADDR_W-1:0] real_addr;
  logic [ADDR_W-1:0] sel_addr;
  logic [ADDR_W-1:0] gated_addr;

  assign mode = addr_mode_e'(prot_mode_i);

  rm_seg_adder #(
    .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .OUT_W(ADDR_W)
  ) u_adder (
    .seg_i(seg_i),
    .off_i(off_i),
    .sum_o(real_addr)
  );

  rm_gate_reg u_gate (
    .clk    (clk),
    .rst    (rst),
    .we_i   (gate_we_i),
    .wdata_i(gate_wdata_i),
    .state_o(gate_state_o)
  );

  always_comb begin
    sel_addr = (mode == MODE_PROT) ? lin_addr_i : real_addr;
  end

  rm_bit_gate #(.W(ADDR_W), .BIT(GATE_BIT)) u_mask (
    .in_i  (sel_addr),
    .pass_i(gate_state_o),
    .out_o (gated_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o       <= '0;
      addr_valid_o <= 1'b0;
    end else begin
      addr_valid_o <= req_valid_i;
      if (req_valid_i) addr_o <= gated_addr;
    end
  end
endmodule

// File: rtl/rm_addr_gen_chk.sv
module rm_addr_gen_chk #(
  parameter int ADDR_W   = 24,
  parameter int GATE_BIT = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic              prot_mode_i,
  input logic [ADDR_W-1:0] lin_addr_i,
  input logic              gate_we_i,
  input logic              gate_wdata_i,
  input logic              gate_state_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_valid_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!addr_valid_o && !gate_state_o && addr_o == '0));

  // R3
  gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !gate_state_o) |=> !addr_o[GATE_BIT]);

  // R2
  real_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !prot_mode_i) |=> addr_o[ADDR_W-1:GATE_BIT+1] == '0);

  // R4
  prot_high_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && prot_mode_i) |=>
      addr_o[ADDR_W-1:GATE_BIT+1] == $past(lin_addr_i[ADDR_W-1:GATE_BIT+1]));

  // R5
  gate_write_chk: assert property (@(posedge clk) disable iff (rst)
    gate_we_i |=> gate_state_o == $past(gate_wdata_i));

  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_we_i |=> $stable(gate_state_o));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> addr_valid_o);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> (!addr_valid_o && $stable(addr_o)));
endmodule

bind rm_addr_gen rm_addr_gen_chk #(.ADDR_W(ADDR_W), .GATE_BIT(GATE_BIT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .prot_mode_i (prot_mode_i),
  .lin_addr_i  (lin_addr_i),
  .gate_we_i   (gate_we_i),
  .gate_wdata_i(gate_wdata_i),
  .gate_state_o(gate_state_o),
  .addr_o      (addr_o),
  .addr_valid_o(addr_valid_o)
);

// File: tb/rm_addr_gen_bench.sv
module rm_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid_i, prot_mode_i, gate_we_i, gate_wdata_i;
  logic [15:0] seg_i, off_i;
  logic [23:0] lin_addr_i;
  logic        gate_state_o, addr_valid_o;
  logic [23:0] addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic gate_exp = 1'b0;

  always #5 clk = ~clk;

  rm_addr_gen u_rm_addr_gen (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .prot_mode_i(prot_mode_i),
    .seg_i(seg_i), .off_i(off_i), .lin_addr_i(lin_addr_i),
    .gate_we_i(gate_we_i), .gate_wdata_i(gate_wdata_i),
    .gate_state_o(gate_state_o), .addr_o(addr_o), .addr_valid_o(addr_valid_o)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_addr(input logic prot, input logic [15:0] s,
                                           input logic [15:0] o, input logic [23:0] l,
                                           input logic g);
    int a;
    a = prot ? int'(l) : int'(s) * 16 + int'(o);
    if (!g) a = a & ~(1 << 20);
    return a[23:0];
  endfunction

  task automatic set_gate(input logic v);
    @(negedge clk);
    gate_we_i = 1'b1; gate_wdata_i = v;
    @(negedge clk);
    gate_we_i = 1'b0;
    gate_exp = v;
    chk("R5 gate write", {23'd0, gate_state_o}, {23'd0, v});
  endtask

  task automatic do_req(input string req, input logic prot, input logic [15:0] s,
                        input logic [15:0] o, input logic [23:0] l);
    @(negedge clk);
    req_valid_i = 1'b1; prot_mode_i = prot; seg_i = s; off_i = o; lin_addr_i = l;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk(req, addr_o, ref_addr(prot, s, o, l, gate_exp));
    chk("R7 valid", {23'd0, addr_valid_o}, 24'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid_i = 0; prot_mode_i = 0; seg_i = 0; off_i = 0;
    lin_addr_i = 0; gate_we_i = 0; gate_wdata_i = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 gate", {23'd0, gate_state_o}, 24'd0);
    chk("R1 valid", {23'd0, addr_valid_o}, 24'd0);
    chk("R1 addr", addr_o, 24'd0);

    // R3 closed-gate corners
    do_req("R3 F800:8000", 1'b0, 16'hF800, 16'h8000, 24'd0);
    chk("R3 F800:8000 lit", addr_o, 24'h000000);
    do_req("R3 FFFF:FFFF", 1'b0, 16'hFFFF, 16'hFFFF, 24'd0);
    chk("R3 FFFF:FFFF lit", addr_o, 24'h00FFEF);

    // R8 aliasing pairs
    do_req("R8 F000:FFFF", 1'b0, 16'hF000, 16'hFFFF, 24'd0);
    chk("R8 lit a", addr_o, 24'h0FFFFF);
    do_req("R8 FFFF:000F", 1'b0, 16'hFFFF, 16'h000F, 24'd0);
    chk("R8 lit b", addr_o, 24'h0FFFFF);
    do_req("R8 F800:7FFF", 1'b0, 16'hF800, 16'h7FFF, 24'd0);
    chk("R8 lit c", addr_o, 24'h0FFFFF);
    do_req("R8 FFF0:00FF", 1'b0, 16'hFFF0, 16'h00FF, 24'd0);
    chk("R8 lit d", addr_o, 24'h0FFFFF);

    // R4 protected mode, gate closed
    do_req("R4 F12345", 1'b1, 16'd0, 16'd0, 24'hF12345);
    chk("R4 F12345 lit", addr_o, 24'hE12345);
    do_req("R4 2ABCDE", 1'b1, 16'd0, 16'd0, 24'h2ABCDE);
    chk("R4 2ABCDE lit", addr_o, 24'h2ABCDE);
    do_req("R4 1FFFFF", 1'b1, 16'd0, 16'd0, 24'h1FFFFF);

    // R7 hold while idle with changing inputs
    @(negedge clk);
    seg_i = 16'h1234; off_i = 16'h5678; lin_addr_i = 24'hABCDEF; prot_mode_i = 1;
    @(negedge clk);
    chk("R7 hold addr", addr_o, 24'h0FFFFF);
    chk("R7 idle valid", {23'd0, addr_valid_o}, 24'd0);

    // R6 write in the same cycle as a request
    @(negedge clk);
    req_valid_i = 1; prot_mode_i = 0; seg_i = 16'hF800; off_i = 16'h8000;
    gate_we_i = 1; gate_wdata_i = 1;
    @(negedge clk);
    req_valid_i = 0; gate_we_i = 0; gate_exp = 1;
    chk("R6 old gate used", addr_o, 24'h000000);
    chk("R6 gate now open", {23'd0, gate_state_o}, 24'd1);

    // R2 open-gate corners
    do_req("R2 F800:8000", 1'b0, 16'hF800, 16'h8000, 24'd0);
    chk("R2 F800:8000 lit", addr_o, 24'h100000);
    do_req("R2 FFFF:FFFF", 1'b0, 16'hFFFF, 16'hFFFF, 24'd0);
    chk("R2 FFFF:FFFF lit", addr_o, 24'h10FFEF);
    do_req("R4 open F12345", 1'b1, 16'd0, 16'd0, 24'hF12345);
    chk("R4 open lit", addr_o, 24'hF12345);

    // R2/R3 sweep under both gate states
    for (int g = 1; g >= 0; g--) begin
      set_gate(g[0]);
      for (int si = 0; si < 256; si++) begin
        for (int oi = 0; oi < 16; oi++) begin
          logic [15:0] s, o;
          s = 16'(si * 257);
          case (oi)
            0: o = 16'h0000;
            1: o = 16'h000F;
            2: o = 16'h8000;
            3: o = 16'hFFFF;
            default: o = 16'(oi * 4093);
          endcase
          do_req(g[0] ? "R2 sweep" : "R3 sweep", 1'b0, s, o, 24'd0);
        end
      end
    end

    // R5 hold without strobe
    repeat (3) @(negedge clk);
    chk("R5 hold", {23'd0, gate_state_o}, 24'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule